// File: doc/BRIEF.md
# Prescaled Pulse-Width Modulator

This block produces one or two pulse-width modulated outputs from a single clock. Each channel has three word registers on a simple single-cycle bus: a control word with a 6-bit clock prescale and a shutdown-mode bit, a duty word with a 10-bit high-time count and a force-high flag, and a period word with a 10-bit terminal count. The prescaler divides the clock by prescale+1. Each prescaler tick advances a period counter from 0 to the terminal count. The output is high while that counter is below the duty count.

A per-channel enable input starts a channel from counter zero. The three settings are copied into shadow copies when the channel starts and again at every period wrap, so a write made while the channel runs never produces a glitched period. When the enable drops, the shutdown bit selects what happens. With the bit clear, the channel finishes its current period. With the bit set, the channel stops on the next clock. The second channel exists only when a build parameter selects it.

Top module: `prescaled_pwm`

## Requirements
- R1: Channel c has its registers at byte addresses c*0x10 plus 0x00 (control), 0x04 (duty) and 0x08 (period). Channel 1 exists only when HAS_CH1 is 1. A write to one channel leaves the other channel's registers unchanged.
- R2: In the control register, bits [5:0] hold the prescale value and bit 6 holds the shutdown-mode bit. A read returns these 7 stored bits, and all higher bits read as zero.
- R3: In the duty register, bits [9:0] hold the duty count DC and bit 10 holds the force-high flag. In the period register, bits [9:0] hold the terminal count PV. Reads return exactly these stored bits, and all other bits read as zero.
- R4: The following addresses are unmapped: any address with addr[1:0] not zero, offsets 0x0C and 0x1C, and channel 1 addresses when that channel is absent. Unmapped addresses read as zero, and writes to them change no register.
- R5: While a channel runs, one output period lasts (prescale+1)*(PV+1) clocks.
- R6: In each period the output is high for the first (prescale+1)*DC clocks and low for the rest.
- R7: When the force-high flag is set, the output stays high for the whole time the channel runs, whatever DC and PV are.
- R8: A DC of 0 without the flag gives a constant low output. A DC of PV+1 or more gives a constant high output.
- R9: A channel starts at the clock edge that first samples its enable high, with both counters at zero. The first output cycle after that edge is the first cycle of a period.
- R10: If the enable is sampled low while the shutdown bit is clear, the output continues until the current period ends. It is low from the cycle after the period's last clock.
- R11: If the enable is sampled low while the shutdown bit is set, the output is low from the very next cycle.
- R12: New prescale, DC, PV and force-high values that are written while a channel runs take effect only at the next period boundary.
- R13: Reset clears every register, and every output is low whenever its channel is not running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the counters and registers |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe; the register at addr takes wrData at the clock edge |
| addr | input | ADDR_W (5) | Byte address for both read and write |
| wrData | input | DATA_W (32) | Write data |
| rdData | output | DATA_W (32) | Read data for addr, combinational |
| chanEn | input | NUM_CH (2) | Per-channel run request |
| pwmOut | output | NUM_CH (2) | Per-channel modulated output |

## Verification
Two functions of this block can fall in the same cycle. A stop request can arrive in the last clock of a period, when the counters wrap. A register write can also land just before the wrap that copies settings into the shadow copies. The bench drops the enable on exactly the wrap cycle and on an earlier cycle. It expects the output to go low in the cycle after the wrap in both cases. The bench also writes new duty and period values mid-period and compares each output cycle against patterns it computes: the old settings for the rest of the period, then the new ones. A near-exhaustive sweep over small prescale, period and duty values checks every output cycle against the formula in R5 and R6.

// File: rtl/ppwm_pkg.sv
package ppwm_pkg;
  parameter int PRE_W = 6;
  parameter int VAL_W = 10;
  localparam int SHUT_BIT = PRE_W;
  localparam int FULL_BIT = VAL_W;
  localparam logic [1:0] SEL_CTRL   = 2'd0;
  localparam logic [1:0] SEL_DUTY   = 2'd1;
  localparam logic [1:0] SEL_PERIOD = 2'd2;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             shut;
    logic [VAL_W-1:0] dc;
    logic             full;
    logic [VAL_W-1:0] pv;
  } chCfg_t;

  typedef struct packed {
    logic start;
    logic run;
    logic outEn;
  } chStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } chState_t;
endpackage

// File: rtl/ppwm_ctrl.sv
module ppwm_ctrl
  import ppwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wrData,
  output logic [DATA_W-1:0]            rdData,
  input  logic [NUM_CH-1:0]            chanEn,
  input  logic [NUM_CH-1:0]            wrapVec,
  output chCfg_t    [NUM_CH-1:0]       cfgVec,
  output chStrobe_t [NUM_CH-1:0]       stbVec
);
  localparam int CH_LSB = 4;
  localparam int IDX_W  = ADDR_W - CH_LSB;

  logic [IDX_W-1:0] chIdx;
  logic [1:0]       regSel;
  logic             mapped;

  assign chIdx  = addr[ADDR_W-1:CH_LSB];
  assign regSel = addr[CH_LSB-1:2];
  assign mapped = (addr[1:0] == 2'b00) && (regSel != 2'd3) && (int'(chIdx) < NUM_CH);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chCfg_t    cfgR;
    chState_t  st, stNxt;
    chStrobe_t stb;
    logic      wrHit;

    assign wrHit = wrEn && mapped && (int'(chIdx) == c);

    // register file for this channel
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgR <= '0;
      end else if (wrHit) begin
        case (regSel)
          SEL_CTRL: begin
            cfgR.pre  <= wrData[PRE_W-1:0];
            cfgR.shut <= wrData[SHUT_BIT];
          end
          SEL_DUTY: begin
            cfgR.dc   <= wrData[VAL_W-1:0];
            cfgR.full <= wrData[FULL_BIT];
          end
          SEL_PERIOD: cfgR.pv <= wrData[VAL_W-1:0];
          default: ;
        endcase
      end
    end

    // run / drain sequencing
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) st <= ST_IDLE;
      else       st <= stNxt;
    end

    always_comb begin
      stNxt     = st;
      stb       = '0;
      stb.outEn = (st != ST_IDLE);
      stb.run   = (st != ST_IDLE);
      case (st)
        ST_IDLE: begin
          if (chanEn[c]) begin
            stb.start = 1'b1;
            stNxt     = ST_RUN;
          end
        end
        ST_RUN: begin
          if (!chanEn[c]) begin
            if (cfgR.shut || wrapVec[c]) stNxt = ST_IDLE;
            else                         stNxt = ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (cfgR.shut || wrapVec[c]) stNxt = ST_IDLE;
        end
        default: stNxt = ST_IDLE;
      endcase
    end

    assign cfgVec[c] = cfgR;
    assign stbVec[c] = stb;
  end

  // read mux
  always_comb begin
    rdData = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (mapped && (int'(chIdx) == c)) begin
        case (regSel)
          SEL_CTRL:   rdData[SHUT_BIT:0] = {cfgVec[c].shut, cfgVec[c].pre};
          SEL_DUTY:   rdData[FULL_BIT:0] = {cfgVec[c].full, cfgVec[c].dc};
          SEL_PERIOD: rdData[VAL_W-1:0]  = cfgVec[c].pv;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ppwm_datapath.sv
module ppwm_datapath
  import ppwm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  chCfg_t    cfg,
  input  chStrobe_t stb,
  output logic      atWrap,
  output logic      pwmOut
);
  logic [PRE_W-1:0] preCnt, shPre;
  logic [VAL_W-1:0] perCnt, shDc, shPv;
  logic             shFull;
  logic             preWrap, perWrap;

  assign preWrap = (preCnt == shPre);
  assign perWrap = (perCnt == shPv);
  assign atWrap  = preWrap && perWrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      perCnt <= '0;
      shPre  <= '0;
      shDc   <= '0;
      shPv   <= '0;
      shFull <= 1'b0;
    end else if (stb.start) begin
      preCnt <= '0;
      perCnt <= '0;
      shPre  <= cfg.pre;
      shDc   <= cfg.dc;
      shPv   <= cfg.pv;
      shFull <= cfg.full;
    end else if (stb.run) begin
      if (preWrap) begin
        preCnt <= '0;
        if (perWrap) begin
          perCnt <= '0;
          shPre  <= cfg.pre;
          shDc   <= cfg.dc;
          shPv   <= cfg.pv;
          shFull <= cfg.full;
        end else begin
          perCnt <= perCnt + VAL_W'(1);
        end
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  // counter never exceeds PV, so DC > PV covers the whole period
  assign pwmOut = stb.outEn && (shFull || (perCnt < shDc));
endmodule

// File: rtl/prescaled_pwm.sv
module prescaled_pwm
  import ppwm_pkg::*;
#(
  parameter bit HAS_CH1 = 1'b1,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  localparam int NUM_CH = HAS_CH1 ? 2 : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [NUM_CH-1:0] chanEn,
  output logic [NUM_CH-1:0] pwmOut
);
  chCfg_t    [NUM_CH-1:0] cfgVec;
  chStrobe_t [NUM_CH-1:0] stbVec;
  logic      [NUM_CH-1:0] wrapVec;

  ppwm_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .chanEn(chanEn), .wrapVec(wrapVec),
    .cfgVec(cfgVec), .stbVec(stbVec)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dp
    ppwm_datapath u_dp (
      .clk(clk), .rstN(rstN), .cfg(cfgVec[c]), .stb(stbVec[c]),
      .atWrap(wrapVec[c]), .pwmOut(pwmOut[c])
    );
  end
endmodule

// File: rtl/ppwm_checker.sv
module ppwm_checker
  import ppwm_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic      [NUM_CH-1:0] chanEn,
  input logic      [NUM_CH-1:0] pwmOut,
  input logic      [NUM_CH-1:0] wrapVec,
  input chCfg_t    [NUM_CH-1:0] cfgVec,
  input chStrobe_t [NUM_CH-1:0] stbVec
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_idle_low_R13: assert property (@(posedge clk) disable iff (!rstN)
      !stbVec[c].outEn |-> !pwmOut[c])
      else $error("idle channel %0d drives high", c);

    assert_full_start_R7: assert property (@(posedge clk) disable iff (!rstN)
      stbVec[c].start && cfgVec[c].full |=> pwmOut[c])
      else $error("force-high start low on channel %0d", c);

    assert_zero_duty_R8: assert property (@(posedge clk) disable iff (!rstN)
      stbVec[c].start && !cfgVec[c].full && (cfgVec[c].dc == '0) |=> !pwmOut[c])
      else $error("zero duty start high on channel %0d", c);

    assert_first_tick_R9: assert property (@(posedge clk) disable iff (!rstN)
      stbVec[c].start && (cfgVec[c].dc != '0) |=> pwmOut[c])
      else $error("first period cycle low on channel %0d", c);

    assert_shut_stop_R11: assert property (@(posedge clk) disable iff (!rstN)
      stbVec[c].outEn && !chanEn[c] && cfgVec[c].shut |=> !stbVec[c].outEn && !pwmOut[c])
      else $error("shutdown stop late on channel %0d", c);

    assert_drain_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
      stbVec[c].outEn && !chanEn[c] && !cfgVec[c].shut && !wrapVec[c] |=> stbVec[c].outEn)
      else $error("drain cut short on channel %0d", c);

    assert_drain_end_R10: assert property (@(posedge clk) disable iff (!rstN)
      stbVec[c].outEn && !chanEn[c] && wrapVec[c] |=> !stbVec[c].outEn)
      else $error("drain overran period on channel %0d", c);
  end
endmodule

bind prescaled_pwm ppwm_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .chanEn(chanEn), .pwmOut(pwmOut),
  .wrapVec(wrapVec), .cfgVec(cfgVec), .stbVec(stbVec)
);

// File: tb/prescaled_pwm_test.sv
module prescaled_pwm_test;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [1:0]  chanEn = '0;
  logic [1:0]  pwmOut;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  prescaled_pwm #(.HAS_CH1(1'b1)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .chanEn(chanEn), .pwmOut(pwmOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rdData, exp);
  endtask

  // one configuration, two full periods, then shutdown stop
  task automatic runCfg(input int ch, input int pre, input int pv, input int dc, input bit full);
    int    per;
    bit    bad;
    logic  actB, expB;
    string tag;
    per  = (pre + 1) * (pv + 1);
    bad  = 1'b0;
    actB = 1'b0;
    expB = 1'b0;
    if (full)            tag = "R7";
    else if (dc == 0)    tag = "R8 zero";
    else if (dc > pv)    tag = "R8 overfull";
    else                 tag = "R5/R6/R9";
    wr(5'(ch * 16 + 0), 32'h40 | 32'(pre));
    wr(5'(ch * 16 + 4), (32'(full) << 10) | 32'(dc));
    wr(5'(ch * 16 + 8), 32'(pv));
    chanEn[ch] = 1'b1;
    for (int i = 0; i < 2 * per; i++) begin
      logic e;
      @(negedge clk);
      e = full || (((i % per) / (pre + 1)) < dc);
      if (!bad && (pwmOut[ch] !== e)) begin
        bad  = 1'b1;
        actB = pwmOut[ch];
        expB = e;
      end
    end
    check($sformatf("%s ch%0d pre=%0d pv=%0d dc=%0d", tag, ch, pre, pv, dc), 32'(actB), 32'(expB));
    chanEn[ch] = 1'b0;
    @(negedge clk);
    check($sformatf("R11 ch%0d pre=%0d pv=%0d dc=%0d", ch, pre, pv, dc), 32'(pwmOut[ch]), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R13 outputs in reset", 32'(pwmOut), 32'd0);
    rstN = 1'b1;
    for (int a = 0; a < 32; a += 4) rdChk($sformatf("R13 reg clear @%0h", a), 5'(a), 32'd0);

    // R1 R2 R3: layout and field widths
    wr(5'h00, 32'hFFFF_FFFF);
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h08, 32'hFFFF_FFFF);
    rdChk("R2 ctrl readback", 5'h00, 32'h7F);
    rdChk("R3 duty readback", 5'h04, 32'h7FF);
    rdChk("R3 period readback", 5'h08, 32'h3FF);
    rdChk("R1 ch1 ctrl untouched", 5'h10, 32'h0);
    rdChk("R1 ch1 duty untouched", 5'h14, 32'h0);
    wr(5'h10, 32'h15);
    wr(5'h14, 32'h405);
    wr(5'h18, 32'h123);
    rdChk("R1 ch1 ctrl", 5'h10, 32'h15);
    rdChk("R1 ch1 duty", 5'h14, 32'h405);
    rdChk("R1 ch1 period", 5'h18, 32'h123);
    rdChk("R1 ch0 ctrl kept", 5'h00, 32'h7F);

    // R4: unmapped
    wr(5'h01, 32'h0);
    wr(5'h0C, 32'h0);
    wr(5'h16, 32'h0);
    wr(5'h1C, 32'h0);
    wr(5'h13, 32'h0);
    rdChk("R4 ch0 ctrl after alias write", 5'h00, 32'h7F);
    rdChk("R4 ch0 period kept", 5'h08, 32'h3FF);
    rdChk("R4 ch1 duty kept", 5'h14, 32'h405);
    rdChk("R4 ch1 ctrl kept", 5'h10, 32'h15);
    rdChk("R4 read 0x0C", 5'h0C, 32'h0);
    rdChk("R4 read 0x1C", 5'h1C, 32'h0);
    rdChk("R4 read 0x01", 5'h01, 32'h0);
    rdChk("R4 read 0x16", 5'h16, 32'h0);

    // near-exhaustive sweep: R5 R6 R7 R8 R9 R11
    for (int pre = 0; pre < 4; pre++) begin
      for (int pv = 0; pv < 5; pv++) begin
        for (int dc = 0; dc <= pv + 2; dc++) runCfg((pre + pv + dc) % 2, pre, pv, dc, 1'b0);
        runCfg((pre + pv) % 2, pre, pv, 0, 1'b1);
      end
    end

    // R10: drain with shutdown clear, stop mid-period
    wr(5'h10, 32'h01);
    wr(5'h14, 32'd5);
    wr(5'h18, 32'd4);
    chanEn[1] = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check($sformatf("R10 mid stop cycle %0d", i), 32'(pwmOut[1]), 32'(i < 10));
      if (i == 3) chanEn[1] = 1'b0;
    end
    // R10: stop requested on the wrap cycle itself
    chanEn[1] = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check($sformatf("R10 wrap stop cycle %0d", i), 32'(pwmOut[1]), 32'(i < 10));
      if (i == 9) chanEn[1] = 1'b0;
    end

    // R11: shutdown set, stop while high
    wr(5'h00, 32'h43);
    wr(5'h04, 32'd8);
    wr(5'h08, 32'd9);
    chanEn[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R11 high before stop", 32'(pwmOut[0]), 32'd1);
    chanEn[0] = 1'b0;
    @(negedge clk);
    check("R11 low after stop", 32'(pwmOut[0]), 32'd0);

    // R12: shadowed update during a period
    wr(5'h00, 32'h40);
    wr(5'h04, 32'd2);
    wr(5'h08, 32'd9);
    chanEn[0] = 1'b1;
    for (int i = 0; i < 20; i++) begin
      logic e;
      @(negedge clk);
      if (i < 10)      e = (i < 2);
      else if (i < 15) e = ((i - 10) < 3);
      else             e = ((i - 15) < 3);
      check($sformatf("R12 cycle %0d", i), 32'(pwmOut[0]), 32'(e));
      if (i == 3) begin
        wrEn = 1'b1; addr = 5'h04; wrData = 32'd3;
      end else if (i == 4) begin
        addr = 5'h08; wrData = 32'd4;
      end else if (i == 5) begin
        wrEn = 1'b0;
      end
    end
    chanEn[0] = 1'b0;
    @(negedge clk);
    check("R13 both idle low", 32'(pwmOut), 32'd0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule